// File: doc/BRIEF.md
# Virtual-Output-Queue Crossbar Matching Scheduler

This block decides, once per timeslot, which inputs of an N-by-N crossbar are connected to which outputs. Each input keeps a separate queue per output. It presents one request bit per non-empty queue, so the scheduler sees a full request matrix rather than one head-of-queue packet per input. This avoids the throughput loss that a single FIFO per input suffers when its head packet waits for a busy output.

A timeslot begins with a one-cycle start pulse, which captures the request matrix. The scheduler then runs round-robin request-grant-accept iterations, one per clock. In each iteration every still-free output grants one still-free requesting input, and every input that received grants accepts one of them. Iterations stop when one adds no pair, or after N iterations, whichever comes first. The resulting matching is conflict-free and cannot be extended. The done flag then rises, and the grant matrix is presented and held until the next start. The grant and accept pointers advance only on pairs formed in the first iteration, which rotates service among competing requesters.

Top module: `voq_crossbar_sched`

## Requirements
- R1: A start pulse while idle (done high or after reset) captures the request matrix. Later changes of the request input, and start pulses while a matching is being computed, have no effect on that timeslot's result.
- R2: In the cycle after an accepted start, done is low and the grant output is all zero until the matching completes.
- R3: In the grant matrix, each input row and each output column holds at most one set bit. Bit i*N+j of both the request and the grant vector means input i to output j.
- R4: A grant bit is set only where the captured request bit is set.
- R5: The matching is maximal: no captured request exists whose input row and output column are both without a grant.
- R6: Done rises at most N clock edges after the edge that accepts start. Done then stays high with an unchanged grant matrix until the next start.
- R7: Grant fairness. After reset every output's grant pointer is at input 0. When all N inputs request only output 0 in consecutive timeslots, output 0 is granted to inputs 0, 1, 2, ..., N-1 in turn.
- R8: Accept fairness. An input whose last first-iteration acceptance was output k, and which requests every output alone, is given outputs k+1, k+2, ... modulo N in successive timeslots.
- R9: After reset, done is low and the grant output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_start | input | 1 | One-cycle pulse that begins a timeslot |
| voq_req | input | N*N | Request matrix, bit i*N+j = input i holds traffic for output j |
| match_done | output | 1 | High when the matching for the current timeslot is complete |
| xbar_grant | output | N*N | Grant matrix, bit i*N+j = input i connected to output j |

## Verification
A corrupted match register or a missed free-flag shows up at done as a doubled row or column, a grant where no request was, or a pair left unmatched. The scoreboard catches all of these in the first completed timeslot. A pointer that moves on a later iteration, or moves to the wrong index, gives no conflict. It appears only as a wrong winner in the rotation sequences, within one to N timeslots. A stuck iteration count shows as a done later than N edges, or as one that never comes.

// File: rtl/voq_sched_pkg.sv
package voq_sched_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } sched_state_e;

   function automatic int ptr_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/voq_rr_pick.sv
// Round-robin picker: the first set bit at or after ptr, wrapping around.
module voq_rr_pick #(
   parameter int N  = 4,
   parameter int PW = voq_sched_pkg::ptr_width(N)
) (
   input  logic [N-1:0]  cand,
   input  logic [PW-1:0] ptr,
   output logic [N-1:0]  pick
);
   localparam bit POW2 = (N & (N - 1)) == 0;

   generate
      if (POW2) begin : g_mask
         always_comb begin
            logic found;
            pick  = '0;
            found = 1'b0;
            for (int k = 0; k < N; k++) begin
               int idx;
               idx = (int'(ptr) + k) & (N - 1);
               if (!found && cand[idx]) begin
                  pick[idx] = 1'b1;
                  found     = 1'b1;
               end
            end
         end
      end else begin : g_mod
         always_comb begin
            logic found;
            pick  = '0;
            found = 1'b0;
            for (int k = 0; k < N; k++) begin
               int idx;
               idx = (int'(ptr) + k) % N;
               if (!found && cand[idx]) begin
                  pick[idx] = 1'b1;
                  found     = 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/voq_rga_iter.sv
// One request-grant-accept iteration over the still-free inputs and outputs.
module voq_rga_iter #(
   parameter int N  = 4,
   parameter int PW = voq_sched_pkg::ptr_width(N)
) (
   input  logic [N-1:0][N-1:0]  req,
   input  logic [N-1:0]         in_free,
   input  logic [N-1:0]         out_free,
   input  logic [N-1:0][PW-1:0] gptr,
   input  logic [N-1:0][PW-1:0] aptr,
   output logic [N-1:0][N-1:0]  acc
);
   logic [N-1:0][N-1:0] col_req;
   logic [N-1:0][N-1:0] gnt;
   logic [N-1:0][N-1:0] gnt_in;

   genvar gi, gj;
   generate
      for (gj = 0; gj < N; gj++) begin : g_out
         for (gi = 0; gi < N; gi++) begin : g_col
            assign col_req[gj][gi] = req[gi][gj] & in_free[gi] & out_free[gj];
            assign gnt_in[gi][gj]  = gnt[gj][gi];
         end
         voq_rr_pick #(.N(N), .PW(PW)) u_grant (
            .cand(col_req[gj]),
            .ptr (gptr[gj]),
            .pick(gnt[gj])
         );
      end
      for (gi = 0; gi < N; gi++) begin : g_in
         voq_rr_pick #(.N(N), .PW(PW)) u_accept (
            .cand(gnt_in[gi]),
            .ptr (aptr[gi]),
            .pick(acc[gi])
         );
      end
   endgenerate
endmodule

// File: rtl/voq_crossbar_sched.sv
module voq_crossbar_sched #(
   parameter int N = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           slot_start,
   input  logic [N*N-1:0] voq_req,
   output logic           match_done,
   output logic [N*N-1:0] xbar_grant
);
   import voq_sched_pkg::*;

   localparam int PW = ptr_width(N);
   localparam int IW = $clog2(N + 1);
   localparam logic [IW-1:0] LAST_ITER = IW'(N - 1);

   generate
      if (N < 2) begin : g_bad_n
         $error("voq_crossbar_sched: N must be at least 2");
      end
   endgenerate

   sched_state_e        state_q;
   logic                run_q;
   logic [N-1:0][N-1:0] req_q;
   logic [N-1:0][N-1:0] match_q;
   logic [N-1:0][N-1:0] acc;
   logic [N-1:0]        in_free;
   logic [N-1:0]        out_free;
   logic [N-1:0][PW-1:0] gptr_q;
   logic [N-1:0][PW-1:0] aptr_q;
   logic [IW-1:0]       iter_q;
   logic                done_q;
   logic                take_start;
   logic                finish;

   assign run_q = (state_q == ST_RUN);

   genvar gi, gj;
   generate
      for (gi = 0; gi < N; gi++) begin : g_row_free
         assign in_free[gi] = ~|match_q[gi];
      end
      for (gj = 0; gj < N; gj++) begin : g_col_free
         logic [N-1:0] col;
         for (gi = 0; gi < N; gi++) begin : g_bit
            assign col[gi] = match_q[gi][gj];
         end
         assign out_free[gj] = ~|col;
      end
   endgenerate

   voq_rga_iter #(.N(N), .PW(PW)) u_iter (
      .req     (req_q),
      .in_free (in_free),
      .out_free(out_free),
      .gptr    (gptr_q),
      .aptr    (aptr_q),
      .acc     (acc)
   );

   assign take_start = slot_start && !run_q;
   assign finish     = run_q && ((acc == '0) || (iter_q == LAST_ITER));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         req_q   <= '0;
         match_q <= '0;
         iter_q  <= '0;
         done_q  <= 1'b0;
      end else if (take_start) begin
         state_q <= ST_RUN;
         req_q   <= voq_req;
         match_q <= '0;
         iter_q  <= '0;
         done_q  <= 1'b0;
      end else if (run_q) begin
         match_q <= match_q | acc;
         iter_q  <= iter_q + 1'b1;
         if (finish) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
         end
      end
   end

   // Pointers move one past the partner, only on first-iteration pairs.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gptr_q <= '0;
         aptr_q <= '0;
      end else if (run_q && (iter_q == '0)) begin
         for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
               if (acc[i][j]) begin
                  gptr_q[j] <= (i == N - 1) ? '0 : PW'(i + 1);
                  aptr_q[i] <= (j == N - 1) ? '0 : PW'(j + 1);
               end
            end
         end
      end
   end

   assign match_done = done_q;
   assign xbar_grant = done_q ? match_q : '0;
endmodule

// File: rtl/voq_sched_chk.sv
module voq_sched_chk #(
   parameter int N = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           slot_start,
   input logic [N*N-1:0] voq_req,
   input logic           match_done,
   input logic [N*N-1:0] xbar_grant,
   input logic [N*N-1:0] held_req,
   input logic           running
);
   int lat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_cnt <= 0;
      else if (slot_start && !running) lat_cnt <= 0;
      else if (running) lat_cnt <= lat_cnt + 1;
   end

   function automatic logic can_extend(input logic [N*N-1:0] r, input logic [N*N-1:0] g);
      logic ext;
      ext = 1'b0;
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < N; j++) begin
            logic busy;
            busy = 1'b0;
            for (int k = 0; k < N; k++) begin
               if (g[i*N+k] || g[k*N+j]) busy = 1'b1;
            end
            if (r[i*N+j] && !busy) ext = 1'b1;
         end
      end
      return ext;
   endfunction

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_lines
         logic [N-1:0] col;
         for (genvar gk = 0; gk < N; gk++) begin : g_c
            assign col[gk] = xbar_grant[gk*N+gi];
         end
         // R3
         row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(xbar_grant[gi*N +: N]));
         // R3
         col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col));
      end
   endgenerate

   // R4
   grant_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_done |-> ((xbar_grant & ~held_req) == '0));
   // R5
   maximal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_done |-> !can_extend(held_req, xbar_grant));
   // R2
   quiet_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !match_done |-> (xbar_grant == '0));
   // R2
   start_drops_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_start && !running) |=> !match_done);
   // R6
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_done && !slot_start) |=> (match_done && $stable(xbar_grant)));
   // R6
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (lat_cnt < N));
   // R1
   hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running)) |-> $stable(held_req));
endmodule

bind voq_crossbar_sched voq_sched_chk #(.N(N)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .slot_start(slot_start),
   .voq_req   (voq_req),
   .match_done(match_done),
   .xbar_grant(xbar_grant),
   .held_req  (req_q),
   .running   (run_q)
);

// File: tb/test_voq_crossbar_sched.sv
module test_voq_crossbar_sched;
   localparam int N  = 4;
   localparam int NN = N * N;

   typedef struct {
      logic [NN-1:0] req;
      int            win_in;
      int            win_out;
      string         tag;
   } slot_item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slot_start = 1'b0;
   logic [NN-1:0] voq_req = '0;
   logic          match_done;
   logic [NN-1:0] xbar_grant;

   int checks = 0;
   int errors = 0;
   slot_item_t sb_q[$];
   logic [31:0] lfsr = 32'h1ACE_B00C;
   logic done_prev = 1'b0;

   always #10 clk = ~clk;

   voq_crossbar_sched #(.N(N)) i_voq_crossbar_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_start(slot_start),
      .voq_req   (voq_req),
      .match_done(match_done),
      .xbar_grant(xbar_grant)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [NN-1:0] act, input logic [NN-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [NN-1:0] next_rand();
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      return lfsr[NN-1:0];
   endfunction

   // Monitor: compare each completed matching against the queued item.
   always @(negedge clk) begin
      if (match_done && !done_prev) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R6", "done without pending slot", xbar_grant, '0);
         end else begin
            slot_item_t it;
            bit rows_ok, cols_ok, max_ok;
            it = sb_q.pop_front();
            rows_ok = 1'b1; cols_ok = 1'b1; max_ok = 1'b1;
            for (int i = 0; i < N; i++) begin
               int rc, cc;
               rc = 0; cc = 0;
               for (int j = 0; j < N; j++) begin
                  rc += xbar_grant[i*N+j];
                  cc += xbar_grant[j*N+i];
               end
               if (rc > 1) rows_ok = 1'b0;
               if (cc > 1) cols_ok = 1'b0;
            end
            for (int i = 0; i < N; i++) begin
               for (int j = 0; j < N; j++) begin
                  bit busy;
                  busy = 1'b0;
                  for (int k = 0; k < N; k++)
                     if (xbar_grant[i*N+k] || xbar_grant[k*N+j]) busy = 1'b1;
                  if (it.req[i*N+j] && !busy) max_ok = 1'b0;
               end
            end
            check(rows_ok, "R3", {it.tag, " row conflict"}, xbar_grant, it.req);
            check(cols_ok, "R3", {it.tag, " column conflict"}, xbar_grant, it.req);
            check((xbar_grant & ~it.req) == '0, "R4", {it.tag, " grant outside request"},
                  xbar_grant, it.req);
            check(max_ok, "R5", {it.tag, " matching extendable"}, xbar_grant, it.req);
            if (it.win_in >= 0) begin
               logic [NN-1:0] exp_g;
               exp_g = '0;
               exp_g[it.win_in*N + it.win_out] = 1'b1;
               check(xbar_grant == exp_g, (it.tag.substr(0, 1)), "rotation winner",
                     xbar_grant, exp_g);
            end
         end
      end
      done_prev = match_done;
   end

   // Driver: queue the expectation, start the slot, wait for completion.
   task automatic run_slot(input logic [NN-1:0] req, input int win_in, input int win_out,
                           input string tag, input bit disturb);
      slot_item_t it;
      int cnt;
      it.req = req; it.win_in = win_in; it.win_out = win_out; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      voq_req    = req;
      slot_start = 1'b1;
      @(negedge clk);
      slot_start = 1'b0;
      cnt = 1;
      check(!match_done && xbar_grant == '0, "R2", "busy outputs", xbar_grant, '0);
      if (disturb) begin
         // R1: new requests and a second start while busy must not matter
         voq_req    = ~req;
         slot_start = 1'b1;
         @(negedge clk);
         slot_start = 1'b0;
         cnt++;
      end
      while (!match_done && cnt <= 3 * N) begin
         @(negedge clk);
         cnt++;
      end
      check(cnt <= N + 1, "R6", "latency", NN'(cnt), NN'(N));
      repeat (2) @(negedge clk);
      begin
         logic [NN-1:0] g0;
         g0 = xbar_grant;
         @(negedge clk);
         check(match_done && xbar_grant == g0, "R6", "done held", xbar_grant, g0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check(!match_done && xbar_grant == '0, "R9", "reset outputs", xbar_grant, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!match_done && xbar_grant == '0, "R9", "after release", xbar_grant, '0);

      // R7: every input wants output 0 only; winner rotates from input 0
      for (int s = 0; s < N; s++) begin
         logic [NN-1:0] r;
         r = '0;
         for (int i = 0; i < N; i++) r[i*N] = 1'b1;
         run_slot(r, s, 0, "R7", 1'b0);
      end
      // R8: input 0 last accepted output 0, so it now gets 1,2,...,0
      for (int s = 0; s < N; s++) begin
         logic [NN-1:0] r;
         r = '0;
         r[N-1:0] = '1;
         run_slot(r, 0, (s + 1) % N, "R8", 1'b0);
      end

      run_slot('0, -1, -1, "zero", 1'b0);
      run_slot('1, -1, -1, "full", 1'b0);
      begin
         logic [NN-1:0] d;
         d = '0;
         for (int i = 0; i < N; i++) d[i*N + (N-1-i)] = 1'b1;
         run_slot(d, -1, -1, "antidiag", 1'b0);
      end
      run_slot(16'h8421 | 16'h1248, -1, -1, "R1 disturbed", 1'b1);
      run_slot(16'h00F1, -1, -1, "R1 disturbed2", 1'b1);
      for (int s = 0; s < 20; s++) run_slot(next_rand(), -1, -1, "random", 1'b0);

      repeat (3) @(negedge clk);
      check(sb_q.size() == 0, "R6", "pending slots", NN'(sb_q.size()), '0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule